// File: doc/BRIEF.md
# CAN Node Mode Sequencer

This block decides when a CAN node moves between normal operation, reset and halt. Software presents a standing mode request and a bus-off handling policy. The protocol engine reports what the node is doing on the bus: receiving, transmitting, at a frame end, bus-off, finishing bus-off recovery, seeing a bus error, losing arbitration, or seeing the bus stuck dominant. The sequencer holds the current mode and applies a request only when the node's role allows it to leave the bus cleanly.

A forced reset takes effect at once. A normal reset waits only for a transmission in flight. A halt waits for the current frame to finish. Bus errors and lost arbitration count as the end of that frame. While the node is bus-off, the policy decides whether a halt happens at once, waits for recovery, or happens without being requested. A bus stuck dominant blocks every halt, so only a reset can take the node off the bus.

Top module: `canctl_mode_seq`

## Requirements
- R1: Mode encoding is 00 = run, 01 = reset, 10 = halt, and 11 never appears. After power-on reset the mode is 01 and the strobe is low.
- R2: Request code 00 (run) moves the node from reset to run on the next clock edge. It also moves the node from halt to run, unless the halt was automatic and software has not yet written a different request since.
- R3: Request code 11 (forced reset) puts the node in reset on the next clock edge, even while it is receiving, transmitting or bus-off.
- R4: Request code 01 (reset) takes effect on the next edge while the node is receiving, idle or bus-off. During a transmission it waits until the transmission ends (frame end or busy flag falling), and a node that turns from transmitter into receiver counts as ended.
- R5: Request code 10 (halt) takes effect on the next edge from reset or from an idle node. While a reception or transmission is active it waits for the frame end or for both busy flags to fall.
- R6: A frame end completes a pending reset or halt even when the transmit busy flag stays high because more frames are queued.
- R7: With policy 00, a halt request made while bus-off waits until bus-off clears. With policy 11, it takes effect on the next edge.
- R8: With policy 01, the node halts automatically on the first edge at which it is running and bus-off. With policy 10, it halts automatically on an edge at which recovery-done is high. After an automatic halt, request 00 keeps the node halted until software writes some other request code.
- R9: While the bus is locked dominant, the mode never becomes halt, by request or automatically. Reset requests still take effect.
- R10: A bus error or lost arbitration during a transmission completes a pending reset or halt on that edge. A bus error during a reception completes a pending halt on that edge.
- R11: The mode-change strobe is high for exactly the clock cycles in which the mode output differs from its value in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_mode | input | 2 | Software request: 00 run, 01 reset, 10 halt, 11 forced reset |
| bo_policy | input | 2 | Bus-off halt policy: 00 on request after recovery, 01 auto at once, 10 auto after recovery, 11 on request at once |
| rx_busy | input | 1 | Node is receiving a frame |
| tx_busy | input | 1 | Node is transmitting or has frames queued |
| frame_end | input | 1 | End of the current frame (one cycle) |
| bus_off | input | 1 | Node is bus-off |
| recov_done | input | 1 | Bus-off recovery completes (one cycle) |
| bus_err | input | 1 | Bus error detected (one cycle) |
| arb_lost | input | 1 | Arbitration lost (one cycle) |
| dom_lock | input | 1 | Bus is locked in the dominant state |
| mode | output | 2 | Current mode |
| mode_chg | output | 1 | One-cycle strobe on each mode change |

## Verification
Each request code is tried with the node in each role: idle, receiving, transmitting, transmitting with more frames queued, and bus-off. This separates requests that must act at once from requests that must wait for a frame end. Frame ends are also replaced by bus errors, lost arbitration and the busy flag falling, which shows which events count as the end of a frame. All four bus-off policies are run through entry to and exit from bus-off, with and without a halt request, which tells automatic halts apart from requested ones. The dominant lock is then raised over both kinds of halt and over a reset, to show that the lock blocks only halts.

// File: rtl/canctl_mode_pkg.sv
package canctl_mode_pkg;
  localparam int MODE_W = 2;
  localparam int CODE_W = 2;

  typedef enum logic [MODE_W-1:0] {
    M_RUN   = 2'b00,
    M_RESET = 2'b01,
    M_HALT  = 2'b10
  } mode_e;

  typedef enum logic [CODE_W-1:0] {
    REQ_RUN   = 2'b00,
    REQ_RESET = 2'b01,
    REQ_HALT  = 2'b10,
    REQ_FORCE = 2'b11
  } req_e;

  typedef enum logic [CODE_W-1:0] {
    BO_REQ_AFTER  = 2'b00,
    BO_AUTO_NOW   = 2'b01,
    BO_AUTO_AFTER = 2'b10,
    BO_REQ_NOW    = 2'b11
  } bo_pol_e;

  // transmitter side is free once nothing is in flight or the frame closed
  function automatic logic tx_released(input logic tx_busy, input logic fend,
                                       input logic berr, input logic alost);
    return !tx_busy || fend || berr || alost;
  endfunction

  // node may leave the bus: no active frame, or the active one just closed
  function automatic logic line_quiet(input logic rx_busy, input logic tx_busy,
                                      input logic fend, input logic berr,
                                      input logic alost);
    return (!rx_busy && !tx_busy) || fend || berr || alost;
  endfunction

  // a halt request while bus-off acts at once under these policies
  function automatic logic halts_in_busoff(input bo_pol_e pol);
    return (pol == BO_AUTO_NOW) || (pol == BO_REQ_NOW);
  endfunction
endpackage

// File: rtl/canctl_mode_decide.sv
module canctl_mode_decide
  import canctl_mode_pkg::*;
(
  input  mode_e   cur_mode,
  input  logic    auto_hold,
  input  req_e    req,
  input  bo_pol_e pol,
  input  logic    rx_busy,
  input  logic    tx_busy,
  input  logic    frame_end,
  input  logic    bus_off,
  input  logic    recov_done,
  input  logic    bus_err,
  input  logic    arb_lost,
  input  logic    dom_lock,
  output mode_e   nxt_mode,
  output logic    rst_go,
  output logic    halt_go,
  output logic    auto_halt,
  output logic    take_auto
);
  logic quiet;

  always_comb begin
    quiet = line_quiet(rx_busy, tx_busy, frame_end, bus_err, arb_lost);

    auto_halt = !dom_lock && (cur_mode == M_RUN) &&
                ((pol == BO_AUTO_NOW && bus_off) ||
                 (pol == BO_AUTO_AFTER && recov_done));

    rst_go = (req == REQ_FORCE) ||
             (req == REQ_RESET &&
              (bus_off || tx_released(tx_busy, frame_end, bus_err, arb_lost)));

    halt_go = (req == REQ_HALT) && !dom_lock &&
              ((cur_mode == M_RESET) ||
               (bus_off ? halts_in_busoff(pol) : quiet));

    nxt_mode  = cur_mode;
    take_auto = 1'b0;
    if (rst_go && cur_mode != M_RESET) begin
      nxt_mode = M_RESET;
    end else if (halt_go && cur_mode != M_HALT) begin
      nxt_mode = M_HALT;
    end else if (auto_halt) begin
      nxt_mode  = M_HALT;
      take_auto = 1'b1;
    end else if (req == REQ_RUN && cur_mode != M_RUN &&
                 !(cur_mode == M_HALT && auto_hold)) begin
      nxt_mode = M_RUN;
    end
  end
endmodule

// File: rtl/canctl_mode_state.sv
module canctl_mode_state
  import canctl_mode_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  mode_e nxt_mode,
  input  logic  take_auto,
  input  logic  req_is_run,
  output mode_e cur_mode,
  output logic  chg,
  output logic  auto_hold
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_mode  <= M_RESET;
      chg       <= 1'b0;
      auto_hold <= 1'b0;
    end else begin
      cur_mode <= nxt_mode;
      chg      <= (nxt_mode != cur_mode);
      if (take_auto)
        auto_hold <= 1'b1;
      else if (!req_is_run)
        auto_hold <= 1'b0;
    end
  end
endmodule

// File: rtl/canctl_mode_seq.sv
module canctl_mode_seq
  import canctl_mode_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] req_mode,
  input  logic [CODE_W-1:0] bo_policy,
  input  logic              rx_busy,
  input  logic              tx_busy,
  input  logic              frame_end,
  input  logic              bus_off,
  input  logic              recov_done,
  input  logic              bus_err,
  input  logic              arb_lost,
  input  logic              dom_lock,
  output logic [MODE_W-1:0] mode,
  output logic              mode_chg
);
  mode_e cur_mode, nxt_mode;
  logic  rst_go, halt_go, auto_halt, take_auto, hold;

  canctl_mode_decide u_decide (
    .cur_mode  (cur_mode),
    .auto_hold (hold),
    .req       (req_e'(req_mode)),
    .pol       (bo_pol_e'(bo_policy)),
    .rx_busy   (rx_busy),
    .tx_busy   (tx_busy),
    .frame_end (frame_end),
    .bus_off   (bus_off),
    .recov_done(recov_done),
    .bus_err   (bus_err),
    .arb_lost  (arb_lost),
    .dom_lock  (dom_lock),
    .nxt_mode  (nxt_mode),
    .rst_go    (rst_go),
    .halt_go   (halt_go),
    .auto_halt (auto_halt),
    .take_auto (take_auto)
  );

  canctl_mode_state u_state (
    .clk       (clk),
    .rst_n     (rst_n),
    .nxt_mode  (nxt_mode),
    .take_auto (take_auto),
    .req_is_run(req_mode == REQ_RUN),
    .cur_mode  (cur_mode),
    .chg       (mode_chg),
    .auto_hold (hold)
  );

  assign mode = cur_mode;
endmodule

// File: rtl/canctl_mode_seq_chk.sv
module canctl_mode_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] req_mode,
  input logic [1:0] bo_policy,
  input logic       rx_busy,
  input logic       tx_busy,
  input logic       frame_end,
  input logic       bus_off,
  input logic       bus_err,
  input logic       arb_lost,
  input logic       dom_lock,
  input logic [1:0] mode,
  input logic       mode_chg,
  input logic       auto_halt,
  input logic       hold
);
  AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    mode != 2'b11); // R1
  AST_RUN_FROM_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    (req_mode == 2'b00 && mode == 2'b01) |=> mode == 2'b00); // R2
  AST_FORCED_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    (req_mode == 2'b11) |=> mode == 2'b01); // R3
  AST_RESET_WAITS_TX: assert property (@(posedge clk) disable iff (!rst_n)
    (req_mode == 2'b01 && mode == 2'b00 && tx_busy && !bus_off && !frame_end &&
     !bus_err && !arb_lost && !auto_halt) |=> mode == 2'b00); // R4
  AST_HALT_WAITS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    (req_mode == 2'b10 && mode == 2'b00 && (rx_busy || tx_busy) && !bus_off &&
     !frame_end && !bus_err && !arb_lost && !auto_halt) |=> mode == 2'b00); // R5
  AST_BUSOFF_HALT_DEFER: assert property (@(posedge clk) disable iff (!rst_n)
    (req_mode == 2'b10 && mode == 2'b00 && bus_off && bo_policy == 2'b00)
    |=> mode == 2'b00); // R7
  AST_AUTO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b10 && hold && req_mode == 2'b00) |=> mode == 2'b10); // R8
  AST_LOCK_NO_HALT: assert property (@(posedge clk) disable iff (!rst_n)
    (dom_lock && mode != 2'b10) |=> mode != 2'b10); // R9
  AST_ERR_ENDS_TX: assert property (@(posedge clk) disable iff (!rst_n)
    (req_mode == 2'b10 && mode == 2'b00 && tx_busy && !bus_off && !dom_lock &&
     (bus_err || arb_lost)) |=> mode == 2'b10); // R10
  AST_STROBE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    mode_chg == (mode != $past(mode))); // R11
endmodule

bind canctl_mode_seq canctl_mode_seq_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_mode (req_mode),
  .bo_policy(bo_policy),
  .rx_busy  (rx_busy),
  .tx_busy  (tx_busy),
  .frame_end(frame_end),
  .bus_off  (bus_off),
  .bus_err  (bus_err),
  .arb_lost (arb_lost),
  .dom_lock (dom_lock),
  .mode     (mode),
  .mode_chg (mode_chg),
  .auto_halt(auto_halt),
  .hold     (hold)
);

// File: tb/canctl_mode_seq_tb.sv
`timescale 1ns/1ps
module canctl_mode_seq_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] req_mode = 2'b01, bo_policy = 2'b00;
  logic       rx_busy = 0, tx_busy = 0, frame_end = 0, bus_off = 0;
  logic       recov_done = 0, bus_err = 0, arb_lost = 0, dom_lock = 0;
  logic [1:0] mode;
  logic       mode_chg;

  int    checks = 0, errors = 0;
  int    em = 1;         // expected mode: 0 run, 1 reset, 2 halt
  bit    ehold = 0;
  bit    echg = 0;
  string tag = "R1";
  bit    finished = 0;

  always #2 clk = ~clk;

  canctl_mode_seq u_dut (
    .clk(clk), .rst_n(rst_n), .req_mode(req_mode), .bo_policy(bo_policy),
    .rx_busy(rx_busy), .tx_busy(tx_busy), .frame_end(frame_end),
    .bus_off(bus_off), .recov_done(recov_done), .bus_err(bus_err),
    .arb_lost(arb_lost), .dom_lock(dom_lock), .mode(mode), .mode_chg(mode_chg)
  );

  task automatic model();
    int  nm = em;
    int  r  = int'(req_mode);
    int  p  = int'(bo_policy);
    bit  autoh, tx_done, quiet;
    autoh   = (em == 0) && !dom_lock &&
              ((p == 1 && bus_off) || (p == 2 && recov_done));
    tx_done = !tx_busy || frame_end || bus_err || arb_lost;
    quiet   = (!rx_busy && !tx_busy) || frame_end || bus_err || arb_lost;
    case (r)
      3: nm = 1;
      1: begin
        if (em != 1 && (bus_off || tx_done)) nm = 1;
        else if (autoh) nm = 2;
      end
      2: begin
        if (em == 1 && !dom_lock) nm = 2;
        else if (em == 0 && !dom_lock &&
                 ((bus_off && (p == 1 || p == 3)) || (!bus_off && quiet) || autoh))
          nm = 2;
      end
      default: begin
        if (autoh) nm = 2;
        else if (em == 1) nm = 0;
        else if (em == 2 && !ehold) nm = 0;
      end
    endcase
    if (em == 0 && nm == 2 && autoh && r != 2) ehold = 1;
    else if (r != 0) ehold = 0;
    echg = (nm != em);
    em   = nm;
  endtask

  task automatic compare();
    checks++;
    if (mode !== 2'(em)) begin
      errors++;
      $display("FAIL %s mode actual=%0d expected=%0d at %0t", tag, mode, em, $time);
    end
    checks++;
    if (mode_chg !== echg) begin
      errors++;
      $display("FAIL %s strobe actual=%0b expected=%0b at %0t", tag, mode_chg, echg, $time);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      model();
      @(negedge clk);
      compare();
    end
  endtask

  task automatic clear_bus();
    rx_busy = 0; tx_busy = 0; frame_end = 0; bus_off = 0;
    recov_done = 0; bus_err = 0; arb_lost = 0; dom_lock = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    tag = "R1";
    echg = 0;
    compare();                       // R1 power-on state
    rst_n = 1;
    step(2);                         // R1 request reset: stays in reset

    tag = "R2";
    req_mode = 2'b00; step(3);       // R2 reset -> run, strobe R11

    tag = "R3";
    rx_busy = 1; tx_busy = 1; req_mode = 2'b11; step(2);
    req_mode = 2'b00; step(1);
    bus_off = 1; req_mode = 2'b11; step(1);
    clear_bus(); req_mode = 2'b00; step(1);

    tag = "R4";
    tx_busy = 1; req_mode = 2'b01; step(3);
    tx_busy = 0; step(1);            // transmission ended
    req_mode = 2'b00; step(1);
    rx_busy = 1; req_mode = 2'b01; step(1);
    rx_busy = 0; req_mode = 2'b00; step(1);
    bus_off = 1; tx_busy = 1; req_mode = 2'b01; step(1);
    clear_bus(); req_mode = 2'b00; step(1);
    tx_busy = 1; req_mode = 2'b01; step(2);
    tx_busy = 0; rx_busy = 1; step(1); // became receiver
    clear_bus(); req_mode = 2'b00; step(1);

    tag = "R5";
    req_mode = 2'b10; step(1);        // idle halt
    req_mode = 2'b00; step(1);
    rx_busy = 1; req_mode = 2'b10; step(3);
    rx_busy = 0; step(1);
    req_mode = 2'b00; step(1);
    tx_busy = 1; req_mode = 2'b10; step(2);
    frame_end = 1; step(1); frame_end = 0; tx_busy = 0;
    req_mode = 2'b01; step(1);        // halt -> reset
    req_mode = 2'b10; step(1);        // reset -> halt at once
    req_mode = 2'b00; step(1);

    tag = "R6";
    tx_busy = 1; req_mode = 2'b01; step(2);
    frame_end = 1; step(1); frame_end = 0;
    req_mode = 2'b00; step(1);
    req_mode = 2'b10; step(2);
    frame_end = 1; step(1); frame_end = 0;
    clear_bus(); req_mode = 2'b00; step(1);

    tag = "R10";
    tx_busy = 1; req_mode = 2'b10; step(2);
    bus_err = 1; step(1); bus_err = 0;
    req_mode = 2'b00; step(1);
    req_mode = 2'b01; step(2);
    arb_lost = 1; step(1); arb_lost = 0;
    req_mode = 2'b00; step(1);
    req_mode = 2'b10; step(1);
    arb_lost = 1; step(1); arb_lost = 0; tx_busy = 0;
    req_mode = 2'b00; step(1);
    rx_busy = 1; req_mode = 2'b10; step(2);
    bus_err = 1; step(1); bus_err = 0;
    clear_bus(); req_mode = 2'b00; step(1);

    tag = "R7";
    bo_policy = 2'b00; bus_off = 1; req_mode = 2'b10; step(3);
    bus_off = 0; recov_done = 1; step(1); recov_done = 0;
    req_mode = 2'b00; step(1);
    bo_policy = 2'b11; bus_off = 1; step(2);
    req_mode = 2'b10; step(1);
    clear_bus(); req_mode = 2'b00; step(1);

    tag = "R8";
    bo_policy = 2'b01; step(1);
    bus_off = 1; step(3);             // auto halt, held
    bus_off = 0; step(2);             // still held by request 00
    req_mode = 2'b10; step(1);        // software writes: hold released
    req_mode = 2'b00; step(2);
    bo_policy = 2'b10; bus_off = 1; step(2);
    bus_off = 0; recov_done = 1; step(1); recov_done = 0;
    step(2);
    req_mode = 2'b01; step(1);
    req_mode = 2'b00; step(2);

    tag = "R9";
    dom_lock = 1; req_mode = 2'b10; step(3);
    bo_policy = 2'b01; bus_off = 1; step(2);
    bus_off = 0; rx_busy = 1; step(1); rx_busy = 0;
    req_mode = 2'b01; step(1);
    req_mode = 2'b10; step(2);        // locked: stays in reset
    dom_lock = 0; step(1);
    bo_policy = 2'b00; req_mode = 2'b00; step(2);

    tag = "R11";
    req_mode = 2'b11; step(1);
    req_mode = 2'b00; step(1);
    req_mode = 2'b10; step(1);
    req_mode = 2'b00; step(2);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule